// File: doc/BRIEF.md
# Machine Check Interrupt Gating Controller

This block sorts hardware error events into four reporting classes and decides which of them may interrupt the processor. The classes are hard damage (system or instruction-processing damage), external damage (timer, clock or I/O storage faults), recovery (errors that hardware already corrected by retry or single-bit ECC), and configuration (buffer block deletions). Each class has a mask bit. An event whose class is masked is held pending and is not lost. When any unmasked class is pending, the block raises a machine check interrupt request and shows the highest-priority class. An acknowledge from the handler takes that class. It also starts a logout to a programmable base address when extended logout is enabled.

Reset leaves the machine quiet for corrected errors. Recovery, configuration and hard-damage reporting are masked. External damage, hard stop and extended logout are enabled, and the logout base resets to 512. Taking a hard-damage interrupt marks a hard check as in progress until the handler signals done. A second hard event during that window, with hard stop enabled, freezes the block at once. The freeze performs no logout and lasts until system reset. No software path can raise the stop.

Top module: `mchk_gate`

## Requirements
- R1: After reset a recovery event (`ev_rcv_i`) does not raise `irq_o`.
- R2: After reset a configuration event (`ev_cfg_i`) does not raise `irq_o`.
- R3: After reset an external-damage event raises `irq_o` on the clock edge that samples it, with `irq_cls_o` = 1.
- R4: The hard-damage class is masked after reset. Writing `psw_we_i` with `psw_mck_i`=1 enables it. Clearing it again masks it.
- R5: A masked event stays pending. Unmasking its class raises `irq_o` on the edge that samples the write.
- R6: Among pending unmasked classes, `irq_cls_o` shows the highest priority: hard damage = 0, then external damage = 1, then recovery = 2, then configuration = 3.
- R7: `ack_i` sampled while `irq_o` is high clears the shown class. `irq_o` then follows the remaining pending classes. `ack_i` while `irq_o` is low has no effect. An event of the shown class in the acknowledging cycle stays pending.
- R8: An accepted acknowledge pulses `logout_start_o` for one cycle after the edge, if control bit 4 (extended logout enable, reset 1) is set. If the bit is clear, there is no pulse.
- R9: `logout_addr_o` takes the logout base register on each logout start. The base resets to 512 and is written through `base_we_i`/`base_wdata_i`.
- R10: A hard event while a hard check is in progress, with control bit 3 (hard stop enable, reset 1) set, raises `hstop_o` on the next edge. From then on `irq_o` and `logout_start_o` stay low, and events and acknowledges have no effect, until reset.
- R11: `done_i` ends the hard check in progress. A hard event in the same cycle as `done_i` is taken as a new pending hard event and does not stop the machine.
- R12: With control bit 3 clear, a nested hard event only pends. Control bits: 0 recovery enable, 1 configuration enable, 2 external enable (reset 1), 3 hard stop enable, 4 extended logout enable.
- R13: Reset clears `hstop_o`, `irq_o` and all pending events, and restores every mask and the base address to their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| ev_hard_i | input | 1 | System or instruction-processing damage event |
| ev_ext_i | input | 1 | External damage event |
| ev_rcv_i | input | 1 | Corrected-error (recovery) event |
| ev_cfg_i | input | 1 | Buffer block deletion event |
| psw_we_i | input | 1 | Write strobe for hard-damage mask |
| psw_mck_i | input | 1 | Hard-damage enable value |
| ctl_we_i | input | 1 | Control mask register write strobe |
| ctl_wdata_i | input | 5 | Control mask register value |
| base_we_i | input | 1 | Logout base write strobe |
| base_wdata_i | input | AW | Logout base value |
| ack_i | input | 1 | Handler accepts the shown interrupt |
| done_i | input | 1 | Handler finished a hard check |
| irq_o | output | 1 | Machine check interrupt request |
| irq_cls_o | output | 2 | Class shown with the request |
| logout_start_o | output | 1 | One-cycle logout start pulse |
| logout_addr_o | output | AW | Logout base address |
| hstop_o | output | 1 | Hard stop, sticky until reset |

## Verification
The two functions that can fall in one cycle are the end of hard-check handling (`done_i`) and the arrival of a new hard event. The same holds for an acknowledge of the hard class and the pending of a fresh hard event. The bench drives `done_i` and `ev_hard_i` in the same cycle and expects a pending hard interrupt with no stop. It later drives a hard event with no done while a check is in progress and expects `hstop_o` with no logout pulse. A behavioural model run on every clock judges every output in each cycle.

// File: rtl/mchk_pkg.sv
package mchk_pkg;
  localparam int NCLS = 4;
  localparam int CW   = $clog2(NCLS);
  localparam int CTLW = 5;
  typedef enum logic [CW-1:0] {
    CLS_HARD = 2'd0,
    CLS_EXT  = 2'd1,
    CLS_RCV  = 2'd2,
    CLS_CFG  = 2'd3
  } cls_e;
  localparam int CB_RCV  = 0;
  localparam int CB_CFG  = 1;
  localparam int CB_EXT  = 2;
  localparam int CB_HSE  = 3;
  localparam int CB_XLOG = 4;
endpackage

// File: rtl/mchk_mask_regs.sv
module mchk_mask_regs
  import mchk_pkg::*;
#(
  parameter int AW       = 16,
  parameter int BASE_RST = 512
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  psw_we_i,
  input  logic                  psw_mck_i,
  input  logic                  ctl_we_i,
  input  logic [CTLW-1:0]       ctl_wdata_i,
  input  logic                  base_we_i,
  input  logic [AW-1:0]         base_wdata_i,
  output logic [NCLS-1:0]       mask_nxt_o,
  output logic                  hse_o,
  output logic                  xlog_o,
  output logic [AW-1:0]         base_o
);
  logic            hard_en_q;
  logic [CTLW-1:0] ctl_q;
  logic            hard_en_nxt;
  logic [CTLW-1:0] ctl_nxt;

  // reset value: external damage, hard stop and extended logout on
  localparam logic [CTLW-1:0] CTL_RST =
    CTLW'((1 << CB_EXT) | (1 << CB_HSE) | (1 << CB_XLOG));

  always_comb begin
    hard_en_nxt = psw_we_i ? psw_mck_i : hard_en_q;
    ctl_nxt     = ctl_we_i ? ctl_wdata_i : ctl_q;
    mask_nxt_o[CLS_HARD] = hard_en_nxt;
    mask_nxt_o[CLS_EXT]  = ctl_nxt[CB_EXT];
    mask_nxt_o[CLS_RCV]  = ctl_nxt[CB_RCV];
    mask_nxt_o[CLS_CFG]  = ctl_nxt[CB_CFG];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hard_en_q <= 1'b0;
      ctl_q     <= CTL_RST;
      base_o    <= AW'(BASE_RST);
    end else begin
      hard_en_q <= hard_en_nxt;
      ctl_q     <= ctl_nxt;
      if (base_we_i) base_o <= base_wdata_i;
    end
  end

  assign hse_o  = ctl_q[CB_HSE];
  assign xlog_o = ctl_q[CB_XLOG];
endmodule

// File: rtl/mchk_pend.sv
module mchk_pend
  import mchk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  input  logic [NCLS-1:0] set_i,
  input  logic [NCLS-1:0] clr_i,
  output logic [NCLS-1:0] pend_nxt_o
);
  logic [NCLS-1:0] pend_q;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    // a new event in the clearing cycle wins over the clear
    assign pend_nxt_o[c] = en_i ? ((pend_q[c] & ~clr_i[c]) | set_i[c]) : pend_q[c];
    always_ff @(posedge clk) begin
      if (rst) pend_q[c] <= 1'b0;
      else     pend_q[c] <= pend_nxt_o[c];
    end
  end
endmodule

// File: rtl/mchk_arb.sv
module mchk_arb
  import mchk_pkg::*;
(
  input  logic [NCLS-1:0] req_i,
  output logic            any_o,
  output logic [CW-1:0]   code_o
);
  always_comb begin
    any_o  = |req_i;
    code_o = '0;
    for (int c = NCLS - 1; c >= 0; c--) begin
      if (req_i[c]) code_o = CW'(c);
    end
  end
endmodule

// File: rtl/mchk_gate.sv
module mchk_gate
  import mchk_pkg::*;
#(
  parameter int AW       = 16,
  parameter int BASE_RST = 512
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_hard_i,
  input  logic            ev_ext_i,
  input  logic            ev_rcv_i,
  input  logic            ev_cfg_i,
  input  logic            psw_we_i,
  input  logic            psw_mck_i,
  input  logic            ctl_we_i,
  input  logic [CTLW-1:0] ctl_wdata_i,
  input  logic            base_we_i,
  input  logic [AW-1:0]   base_wdata_i,
  input  logic            ack_i,
  input  logic            done_i,
  output logic            irq_o,
  output logic [CW-1:0]   irq_cls_o,
  output logic            logout_start_o,
  output logic [AW-1:0]   logout_addr_o,
  output logic            hstop_o
);
  logic [NCLS-1:0] mask_nxt, pend_nxt, ev_vec, clr_vec;
  logic            hse, xlog;
  logic [AW-1:0]   base;
  logic            busy_q, busy_nxt, stop_nxt, take, any, lst_nxt;
  logic [CW-1:0]   code;

  mchk_mask_regs #(.AW(AW), .BASE_RST(BASE_RST)) u_regs (
    .clk(clk), .rst(rst),
    .psw_we_i(psw_we_i), .psw_mck_i(psw_mck_i),
    .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
    .base_we_i(base_we_i), .base_wdata_i(base_wdata_i),
    .mask_nxt_o(mask_nxt), .hse_o(hse), .xlog_o(xlog), .base_o(base)
  );

  always_comb begin
    ev_vec           = '0;
    ev_vec[CLS_HARD] = ev_hard_i;
    ev_vec[CLS_EXT]  = ev_ext_i;
    ev_vec[CLS_RCV]  = ev_rcv_i;
    ev_vec[CLS_CFG]  = ev_cfg_i;
    take             = ack_i & irq_o & ~hstop_o;
    clr_vec          = '0;
    if (take) clr_vec[irq_cls_o] = 1'b1;
    // nested hard error while the previous one is still open
    stop_nxt = hstop_o | (ev_hard_i & busy_q & ~done_i & hse);
    busy_nxt = hstop_o ? busy_q
             : ((busy_q & ~done_i) | (take & (irq_cls_o == CLS_HARD)));
    lst_nxt  = take & xlog & ~stop_nxt;
  end

  mchk_pend u_pend (
    .clk(clk), .rst(rst), .en_i(~hstop_o),
    .set_i(ev_vec), .clr_i(clr_vec), .pend_nxt_o(pend_nxt)
  );

  mchk_arb u_arb (
    .req_i(pend_nxt & mask_nxt), .any_o(any), .code_o(code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q         <= 1'b0;
      hstop_o        <= 1'b0;
      irq_o          <= 1'b0;
      irq_cls_o      <= '0;
      logout_start_o <= 1'b0;
      logout_addr_o  <= AW'(BASE_RST);
    end else begin
      busy_q         <= busy_nxt;
      hstop_o        <= stop_nxt;
      irq_o          <= any & ~stop_nxt;
      irq_cls_o      <= code;
      logout_start_o <= lst_nxt;
      if (lst_nxt) logout_addr_o <= base;
    end
  end
endmodule

// File: rtl/mchk_gate_chk.sv
module mchk_gate_chk
  import mchk_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ev_hard_i,
  input logic          ack_i,
  input logic          irq_o,
  input logic          logout_start_o,
  input logic [AW-1:0] logout_addr_o,
  input logic          hstop_o
);
  p_stop_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    hstop_o |=> hstop_o);
  p_stop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    hstop_o |-> (!irq_o && !logout_start_o));
  p_stop_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(hstop_o) |-> $past(ev_hard_i));
  p_lstart_ack_r8: assert property (@(posedge clk) disable iff (rst)
    logout_start_o |-> $past(ack_i && irq_o));
  p_addr_move_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(logout_addr_o) |-> logout_start_o);
endmodule

bind mchk_gate mchk_gate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ev_hard_i(ev_hard_i), .ack_i(ack_i),
  .irq_o(irq_o), .logout_start_o(logout_start_o),
  .logout_addr_o(logout_addr_o), .hstop_o(hstop_o)
);

// File: tb/mchk_gate_tb_top.sv
module mchk_gate_tb_top;
  localparam int AW = 16;
  logic clk = 1'b0, rst = 1'b1;
  logic ev_hard = 0, ev_ext = 0, ev_rcv = 0, ev_cfg = 0;
  logic psw_we = 0, psw_mck = 0, ctl_we = 0, base_we = 0, ack = 0, done = 0;
  logic [4:0]    ctl_wd = '0;
  logic [AW-1:0] base_wd = '0;
  logic          irq, lst, hstop;
  logic [1:0]    cls;
  logic [AW-1:0] addr;
  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  mchk_gate #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .ev_hard_i(ev_hard), .ev_ext_i(ev_ext),
    .ev_rcv_i(ev_rcv), .ev_cfg_i(ev_cfg), .psw_we_i(psw_we), .psw_mck_i(psw_mck),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd), .base_we_i(base_we),
    .base_wdata_i(base_wd), .ack_i(ack), .done_i(done), .irq_o(irq),
    .irq_cls_o(cls), .logout_start_o(lst), .logout_addr_o(addr), .hstop_o(hstop)
  );

  // behavioural reference model
  bit m_pend[4];
  bit m_en[4];
  bit m_hse, m_xlog, m_busy, m_stop, m_irq, m_lst;
  int m_cls, m_base, m_addr;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_pend[i]) m_pend[i] = 0;
      m_en[0] = 0; m_en[1] = 1; m_en[2] = 0; m_en[3] = 0;
      m_hse = 1; m_xlog = 1; m_busy = 0; m_stop = 0; m_irq = 0; m_lst = 0;
      m_cls = 0; m_base = 512; m_addr = 512;
    end else begin
      bit take, stopn, hse_old, xlog_old, found;
      int base_old;
      bit evs[4];
      evs[0] = ev_hard; evs[1] = ev_ext; evs[2] = ev_rcv; evs[3] = ev_cfg;
      take = ack && m_irq && !m_stop;
      hse_old = m_hse; xlog_old = m_xlog; base_old = m_base;
      stopn = m_stop || (ev_hard && m_busy && !done && hse_old);
      if (psw_we) m_en[0] = psw_mck;
      if (ctl_we) begin
        m_en[2] = ctl_wd[0]; m_en[3] = ctl_wd[1]; m_en[1] = ctl_wd[2];
        m_hse = ctl_wd[3]; m_xlog = ctl_wd[4];
      end
      if (base_we) m_base = int'(base_wd);
      if (!m_stop) begin
        if (take) m_pend[m_cls] = 0;
        foreach (evs[i]) if (evs[i]) m_pend[i] = 1;
        m_busy = (m_busy && !done) || (take && m_cls == 0);
      end
      m_lst = take && xlog_old && !stopn;
      if (m_lst) m_addr = base_old;
      m_stop = stopn;
      found = 0; m_cls = 0;
      for (int i = 0; i < 4; i++)
        if (!found && m_pend[i] && m_en[i]) begin found = 1; m_cls = i; end
      m_irq = found && !stopn;
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      cmp("R3 irq model", int'(irq), int'(m_irq));
      if (m_irq) cmp("R6 cls model", int'(cls), m_cls);
      cmp("R8 logout model", int'(lst), int'(m_lst));
      cmp("R9 addr model", int'(addr), m_addr);
      cmp("R10 stop model", int'(hstop), int'(m_stop));
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // inputs set by caller before, cleared after one edge
  task automatic cyc();
    @(negedge clk);
    ev_hard = 0; ev_ext = 0; ev_rcv = 0; ev_cfg = 0;
    psw_we = 0; ctl_we = 0; base_we = 0; ack = 0; done = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cmp("R13 reset irq", int'(irq), 0);
    cmp("R13 reset stop", int'(hstop), 0);
    cmp("R9 reset base", int'(addr), 512);
    ev_rcv = 1; cyc(); cmp("R1 recovery masked", int'(irq), 0);
    ev_cfg = 1; cyc(); cmp("R2 config masked", int'(irq), 0);
    ctl_we = 1; ctl_wd = 5'b11101; cyc();
    cmp("R5 unmask raises", int'(irq), 1); cmp("R5 class", int'(cls), 2);
    ev_ext = 1; cyc(); cmp("R3 ext class", int'(cls), 1);
    ev_hard = 1; cyc(); cmp("R4 hard masked", int'(cls), 1);
    psw_we = 1; psw_mck = 1; cyc(); cmp("R4 hard enabled", int'(cls), 0);
    ack = 1; cyc();
    cmp("R8 logout pulse", int'(lst), 1); cmp("R9 addr", int'(addr), 512);
    cmp("R6 next ext", int'(cls), 1);
    ack = 1; cyc(); cmp("R7 next rcv", int'(cls), 2);
    ctl_we = 1; ctl_wd = 5'b11111; cyc(); cmp("R6 rcv over cfg", int'(cls), 2);
    ack = 1; cyc(); cmp("R6 cfg last", int'(cls), 3);
    ack = 1; ev_cfg = 1; cyc(); cmp("R7 event in ack cycle pends", int'(irq), 1);
    ack = 1; cyc(); cmp("R7 all taken", int'(irq), 0);
    ack = 1; cyc(); cmp("R7 ack ignored", int'(lst), 0);
    done = 1; ev_hard = 1; cyc();
    cmp("R11 no stop", int'(hstop), 0); cmp("R11 pending hard", int'(irq), 1);
    base_we = 1; base_wd = 16'd1000; cyc();
    ack = 1; cyc(); cmp("R9 new base", int'(addr), 1000);
    ctl_we = 1; ctl_wd = 5'b10111; cyc();
    ev_hard = 1; cyc();
    cmp("R12 no stop", int'(hstop), 0); cmp("R12 pends", int'(irq), 1);
    ctl_we = 1; ctl_wd = 5'b01111; cyc();
    ack = 1; cyc(); cmp("R8 logout off", int'(lst), 0);
    ev_hard = 1; cyc();
    cmp("R10 stop", int'(hstop), 1); cmp("R10 irq off", int'(irq), 0);
    ev_ext = 1; cyc(); cyc();
    cmp("R10 sticky", int'(hstop), 1); cmp("R10 ext ignored", int'(irq), 0);
    rst = 1; cyc(); cyc(); rst = 0;
    cmp("R13 stop cleared", int'(hstop), 0);
    cmp("R13 base default", int'(addr), 512);
    ev_rcv = 1; cyc(); cmp("R13 rcv remasked", int'(irq), 0);
    ev_hard = 1; cyc(); cmp("R13 hard remasked", int'(irq), 0);
    ev_ext = 1; cyc(); cmp("R13 ext on", int'(irq), 1);
    repeat (3) cyc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule